// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading translation descriptors from memory. A walk starts with an entry chosen from a context table by the current context number; every descriptor fetched after that either points at the next, smaller table or ends the walk with a leaf. A leaf can sit at any level, so one descriptor can map the whole 4 GB space, a 16 MB region, a 256 KB region or a 4 KB page. The walker returns the physical address with the leaf's low attribute byte, or it flags a fault and records where the walk stopped.

A small register file holds an enable bit, the pre-shifted context table pointer and the context number. It also exposes the status and virtual address of the most recent fault. When translation is disabled, requests are echoed back untranslated without touching memory. When the leaf's referenced bit, or for writes its modified bit, is clear, the walker writes the updated leaf back to memory before it answers. Descriptor traffic uses a single-outstanding request/acknowledge port.

Top module: `ptw_top`

## Requirements
- R1: After reset the request port is ready, no response or memory request is active, and every configuration register reads zero.
- R2: Configuration offsets: 0x000 control (bit 0 = translation enable), 0x100 table pointer (bits 31:4 kept, bits 3:0 read zero), 0x200 context number, 0x300 fault status, 0x400 fault address. Writes to 0x300 and 0x400 are ignored. Unmapped offsets read zero.
- R3: With translation disabled, a request produces no memory access and answers with the zero-extended virtual address, attribute byte 0 and no fault.
- R4: The first fetch reads `{ptr[31:4],8'h00} + 4*context`. After a pointer descriptor d, the next fetch reads `{d[31:4],8'h00} + 4*index`, where the index is VA[31:24], then VA[23:18], then VA[17:12].
- R5: Descriptor bits 1:0 give the type: 0 invalid, 1 next-table pointer, 2 and 3 leaf.
- R6: A leaf at level L (0 = context entry) gives the physical address `{leaf[31:8],12'h000}`, with its low K bits taken from the zero-extended virtual address, where K is 32, 24, 18 or 12 for L = 0..3.
- R7: An invalid descriptor ends the walk with a fault. Fault status bits 3:2 hold the level and bits 1:0 hold 1. The fault address register holds the virtual address. The response carries a zero address and a zero attribute byte.
- R8: A pointer descriptor at level 3 ends the walk with a fault of type 2 at level 3.
- R9: If the leaf's referenced bit 5 is clear, or a write finds its modified bit 6 clear, the leaf is written back to its own address with bit 5 set (and bit 6 set for writes). The response attribute byte is the updated low byte.
- R10: Otherwise no write is issued, and the attribute byte is the fetched leaf's low byte.
- R11: The response is valid in the cycle after the edge that completes the last memory access. For a disabled request it is valid in the cycle after acceptance.
- R12: The block takes no new request until a response is given. A memory request keeps its address, direction and data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 11 | Configuration offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data, combinational from offset |
| req_valid_i | input | 1 | Translation request valid |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | Request is a store |
| req_ready_o | output | 1 | Walker idle, request accepted |
| resp_valid_o | output | 1 | One-cycle result strobe |
| resp_fault_o | output | 1 | Walk ended in a fault |
| resp_paddr_o | output | 36 | Physical address |
| resp_attr_o | output | 8 | Leaf low byte after any update |
| mem_req_o | output | 1 | Descriptor access request |
| mem_we_o | output | 1 | Access is a write-back |
| mem_addr_o | output | 36 | Descriptor byte address |
| mem_wdata_o | output | 32 | Write-back data |
| mem_ack_i | input | 1 | Access completed |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
The bench memory acknowledges every request at the falling edge after the request appears, so each descriptor access takes exactly one cycle. A walk with N accesses (including a write-back) therefore answers N+1 rising edges after the edge the request is driven before, and a disabled request answers after one. The driver stamps each expected item with the cycle count at which it drives the request. The monitor, sampling on falling edges, compares the elapsed count together with address, attributes and fault flag. Fault registers and memory write-backs are read through the normal ports once the scoreboard has drained.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int DW        = 32;
  localparam int VA_W      = 32;
  localparam int TBL_SHIFT = 4;
  localparam int PA_W      = DW + TBL_SHIFT;
  localparam int CFG_AW    = 11;
  localparam int LVL_W     = 2;
  localparam logic [LVL_W-1:0] LAST_LVL = 2'd3;

  // low bit of the VA offset kept by a leaf / index lsb at each level
  localparam int LVL_LSB [4] = '{32, 24, 18, 12};
  localparam int LVL_IDX [4] = '{8, 8, 6, 6};

  localparam int BIT_REF = 5;
  localparam int BIT_MOD = 6;

  typedef enum logic [1:0] {
    ET_INV  = 2'd0,
    ET_PTR  = 2'd1,
    ET_LEAF = 2'd2,
    ET_ALT  = 2'd3
  } etype_e;

  typedef enum logic [1:0] {
    FT_NONE    = 2'd0,
    FT_INVALID = 2'd1,
    FT_DEPTH   = 2'd2
  } ftype_e;

  localparam logic [CFG_AW-1:0] OFS_CTRL = 11'h000;
  localparam logic [CFG_AW-1:0] OFS_TPTR = 11'h100;
  localparam logic [CFG_AW-1:0] OFS_CTX  = 11'h200;
  localparam logic [CFG_AW-1:0] OFS_FSR  = 11'h300;
  localparam logic [CFG_AW-1:0] OFS_FAR  = 11'h400;
endpackage

// File: rtl/ptw_regs.sv
module ptw_regs
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [CFG_AW-1:0]       cfg_addr_i,
  input  logic [DW-1:0]           cfg_wdata_i,
  output logic [DW-1:0]           cfg_rdata_o,
  input  logic                    fault_we_i,
  input  logic [2*LVL_W-1:0]      fault_status_i,
  input  logic [VA_W-1:0]         fault_addr_i,
  output logic                    enable_o,
  output logic [DW-1:0]           tptr_o,
  output logic [CTX_W-1:0]        ctx_o
);
  logic                   en_q;
  logic [DW-1:TBL_SHIFT]  tptr_q;
  logic [CTX_W-1:0]       ctx_q;
  logic [2*LVL_W-1:0]     fsr_q;
  logic [VA_W-1:0]        far_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      tptr_q <= '0;
      ctx_q  <= '0;
      fsr_q  <= '0;
      far_q  <= '0;
    end else begin
      if (cfg_we_i) begin
        unique case (cfg_addr_i)
          OFS_CTRL: en_q   <= cfg_wdata_i[0];
          OFS_TPTR: tptr_q <= cfg_wdata_i[DW-1:TBL_SHIFT];
          OFS_CTX:  ctx_q  <= cfg_wdata_i[CTX_W-1:0];
          default: ;
        endcase
      end
      if (fault_we_i) begin
        fsr_q <= fault_status_i;
        far_q <= fault_addr_i;
      end
    end
  end

  always_comb begin
    unique case (cfg_addr_i)
      OFS_CTRL: cfg_rdata_o = DW'(en_q);
      OFS_TPTR: cfg_rdata_o = {tptr_q, {TBL_SHIFT{1'b0}}};
      OFS_CTX:  cfg_rdata_o = DW'(ctx_q);
      OFS_FSR:  cfg_rdata_o = DW'(fsr_q);
      OFS_FAR:  cfg_rdata_o = far_q;
      default:  cfg_rdata_o = '0;
    endcase
  end

  assign enable_o = en_q;
  assign tptr_o   = {tptr_q, {TBL_SHIFT{1'b0}}};
  assign ctx_o    = ctx_q;

  // software cannot overwrite fault state
  p_ro_fault_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !fault_we_i && (cfg_addr_i == OFS_FSR || cfg_addr_i == OFS_FAR))
    |=> ($stable(fsr_q) && $stable(far_q)));
endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [DW-1:0]    tptr_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic [DW-1:0]    ptr_i,
  input  logic [DW-1:0]    pte_i,
  output logic [PA_W-1:0]  fetch_addr_o,
  output logic [PA_W-1:0]  paddr_o
);
  localparam int IDX_MAX = 8;

  logic [IDX_MAX-1:0] idx [4];
  logic [PA_W-1:0]    ctx_base, ptr_base, leaf_base, keep_mask, tbl_base;

  assign idx[0] = IDX_MAX'(ctx_i);
  for (genvar lv = 1; lv < 4; lv++) begin : g_idx
    assign idx[lv] = IDX_MAX'(va_i[LVL_LSB[lv] +: LVL_IDX[lv]]);
  end

  assign ctx_base  = {tptr_i[DW-1:TBL_SHIFT], {2*TBL_SHIFT{1'b0}}};
  assign ptr_base  = {ptr_i[DW-1:TBL_SHIFT], {2*TBL_SHIFT{1'b0}}};
  assign leaf_base = {pte_i[DW-1:8], 12'h000};

  always_comb begin
    tbl_base     = (lvl_i == '0) ? ctx_base : ptr_base;
    fetch_addr_o = tbl_base + PA_W'({idx[lvl_i], 2'b00});
    keep_mask    = (PA_W'(1) << LVL_LSB[lvl_i]) - PA_W'(1);
    paddr_o      = (leaf_base & ~keep_mask) | (PA_W'(va_i) & keep_mask);
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic               req_write_i,
  output logic               req_ready_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic [LVL_W-1:0]   lvl_o,
  output logic [VA_W-1:0]    va_o,
  output logic [DW-1:0]      ptr_o,
  output logic [DW-1:0]      pte_o,
  input  logic [PA_W-1:0]    pa_i,
  output logic               resp_valid_o,
  output logic               resp_fault_o,
  output logic [PA_W-1:0]    resp_paddr_o,
  output logic [7:0]         resp_attr_o,
  output logic               fault_we_o,
  output logic [2*LVL_W-1:0] fault_status_o
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_UPD} st_e;

  st_e              st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [DW-1:0]    ptr_q, pte_q;
  logic             rv_q, rf_q;
  logic [PA_W-1:0]  rpa_q;
  logic [7:0]       rat_q;

  etype_e        et;
  logic          need_upd;
  logic [DW-1:0] upd_pte;
  ftype_e        ftype;

  assign et       = etype_e'(mem_rdata_i[1:0]);
  assign need_upd = !mem_rdata_i[BIT_REF] || (wr_q && !mem_rdata_i[BIT_MOD]);
  assign upd_pte  = mem_rdata_i | (DW'(1) << BIT_REF) | (wr_q ? (DW'(1) << BIT_MOD) : '0);

  always_comb begin
    ftype = FT_NONE;
    if (st_q == S_FETCH && mem_ack_i) begin
      if (et == ET_INV) ftype = FT_INVALID;
      else if (et == ET_PTR && lvl_q == LAST_LVL) ftype = FT_DEPTH;
    end
  end

  assign fault_we_o     = (ftype != FT_NONE);
  assign fault_status_o = {lvl_q, ftype};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      lvl_q <= '0;
      va_q  <= '0;
      wr_q  <= 1'b0;
      ptr_q <= '0;
      pte_q <= '0;
      rv_q  <= 1'b0;
      rf_q  <= 1'b0;
      rpa_q <= '0;
      rat_q <= '0;
    end else begin
      rv_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          va_q <= req_vaddr_i;
          wr_q <= req_write_i;
          if (!enable_i) begin
            rv_q  <= 1'b1;
            rf_q  <= 1'b0;
            rpa_q <= PA_W'(req_vaddr_i);
            rat_q <= '0;
          end else begin
            lvl_q <= '0;
            st_q  <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack_i) begin
          if (ftype != FT_NONE) begin
            rv_q  <= 1'b1;
            rf_q  <= 1'b1;
            rpa_q <= '0;
            rat_q <= '0;
            st_q  <= S_IDLE;
          end else if (et == ET_PTR) begin
            ptr_q <= mem_rdata_i;
            lvl_q <= lvl_q + 1'b1;
          end else begin
            pte_q <= upd_pte;
            if (need_upd) begin
              st_q <= S_UPD;
            end else begin
              rv_q  <= 1'b1;
              rf_q  <= 1'b0;
              rpa_q <= pa_i;
              rat_q <= mem_rdata_i[7:0];
              st_q  <= S_IDLE;
            end
          end
        end
        S_UPD: if (mem_ack_i) begin
          rv_q  <= 1'b1;
          rf_q  <= 1'b0;
          rpa_q <= pa_i;
          rat_q <= pte_q[7:0];
          st_q  <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (st_q == S_IDLE);
  assign mem_req_o    = (st_q != S_IDLE);
  assign mem_we_o     = (st_q == S_UPD);
  assign mem_wdata_o  = pte_q;
  assign lvl_o        = lvl_q;
  assign va_o         = va_q;
  assign ptr_o        = ptr_q;
  assign pte_o        = (st_q == S_FETCH) ? mem_rdata_i : pte_q;
  assign resp_valid_o = rv_q;
  assign resp_fault_o = rf_q;
  assign resp_paddr_o = rpa_q;
  assign resp_attr_o  = rat_q;

  p_wb_sets_ref_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[BIT_REF]);

  p_fault_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_fault_o) |-> (resp_paddr_o == '0 && resp_attr_o == '0));

  p_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !enable_i) |=>
      (resp_valid_o && !resp_fault_o && resp_paddr_o == PA_W'($past(req_vaddr_i))));

  p_resp_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> ($past(mem_ack_i && mem_req_o) || $past(req_valid_i && req_ready_o && !enable_i)));
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [10:0]       cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic [31:0]       req_vaddr_i,
  input  logic              req_write_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic              resp_fault_o,
  output logic [35:0]       resp_paddr_o,
  output logic [7:0]        resp_attr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [35:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  logic                 enable;
  logic [DW-1:0]        tptr;
  logic [CTX_W-1:0]     ctx;
  logic                 fault_we;
  logic [2*LVL_W-1:0]   fault_status;
  logic [LVL_W-1:0]     lvl;
  logic [VA_W-1:0]      va;
  logic [DW-1:0]        ptr, pte;
  logic [PA_W-1:0]      pa;

  ptw_regs #(.CTX_W(CTX_W)) i_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .fault_we_i(fault_we), .fault_status_i(fault_status), .fault_addr_i(va),
    .enable_o(enable), .tptr_o(tptr), .ctx_o(ctx)
  );

  ptw_addr #(.CTX_W(CTX_W)) i_addr (
    .lvl_i(lvl), .va_i(va), .tptr_i(tptr), .ctx_i(ctx), .ptr_i(ptr), .pte_i(pte),
    .fetch_addr_o(mem_addr_o), .paddr_o(pa)
  );

  ptw_ctrl i_ctrl (
    .clk_i, .rst_ni, .enable_i(enable),
    .req_valid_i, .req_vaddr_i, .req_write_i, .req_ready_o,
    .mem_req_o, .mem_we_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .lvl_o(lvl), .va_o(va), .ptr_o(ptr), .pte_o(pte), .pa_i(pa),
    .resp_valid_o, .resp_fault_o, .resp_paddr_o, .resp_attr_o,
    .fault_we_o(fault_we), .fault_status_o(fault_status)
  );

  p_mem_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  p_busy_no_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
endmodule

// File: tb/test_ptw_top.sv
`timescale 1ns/1ps
module test_ptw_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [10:0] cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_ready_o, resp_valid_o, resp_fault_o;
  logic [35:0] resp_paddr_o;
  logic [7:0]  resp_attr_o;
  logic        mem_req_o, mem_we_o;
  logic [35:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  ptw_top i_ptw_top (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    logic        fault;
    logic [35:0] pa;
    logic [7:0]  attr;
    int          lat;
    int          t0;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          errors = 0, checks = 0, cyc = 0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] mem [logic [35:0]];

  // reference walk state and results
  bit          m_en;
  logic [31:0] m_tptr;
  logic [7:0]  m_ctx;
  logic        m_fault, m_wb;
  logic [35:0] m_pa, m_wb_addr;
  logic [31:0] m_wb_data;
  logic [7:0]  m_attr;
  logic [3:0]  m_fsr;
  int          m_k;

  function automatic logic [31:0] rd(input logic [35:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) cyc++;

  // zero-wait memory: acknowledge at the falling edge after a request shows
  always @(negedge clk_i) begin
    mem_ack_i = mem_req_o;
    if (mem_req_o) begin
      if (mem_we_o) begin
        mem[mem_addr_o] = mem_wdata_o;
        wr_cnt++;
      end else begin
        mem_rdata_i = rd(mem_addr_o);
        rd_cnt++;
      end
    end
  end

  // monitor
  always @(negedge clk_i) begin
    if (resp_valid_o) begin
      if (sb_q.size() == 0) begin
        chk(0, "R11 unexpected response", 64'(resp_paddr_o), 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(resp_fault_o == e.fault, {e.tag, " fault"}, 64'(resp_fault_o), 64'(e.fault));
        chk(resp_paddr_o == e.pa, {e.tag, " paddr"}, 64'(resp_paddr_o), 64'(e.pa));
        chk(resp_attr_o == e.attr, {e.tag, " attr"}, 64'(resp_attr_o), 64'(e.attr));
        chk((cyc - e.t0) == e.lat, "R11 latency", 64'(cyc - e.t0), 64'(e.lat));
      end
    end
  end

  task automatic model(input logic [31:0] va, input bit wr);
    logic [35:0] a, mask;
    logic [31:0] d, nd;
    logic [1:0]  lvl;
    logic [7:0]  idx;
    bit          done;
    m_fault = 0; m_wb = 0; m_pa = '0; m_attr = '0; m_fsr = '0; m_k = 0;
    m_wb_addr = '0; m_wb_data = '0;
    if (!m_en) begin
      m_pa = {4'h0, va};
      return;
    end
    a = {m_tptr[31:4], 8'h00} + 36'(m_ctx) * 4;
    lvl = 0;
    done = 0;
    while (!done) begin
      d = rd(a);
      m_k++;
      if (d[1:0] == 2'd0) begin
        m_fault = 1; m_fsr = {lvl, 2'd1}; done = 1;
      end else if (d[1:0] == 2'd1) begin
        if (lvl == 2'd3) begin
          m_fault = 1; m_fsr = {2'd3, 2'd2}; done = 1;
        end else begin
          lvl = lvl + 1;
          idx = (lvl == 1) ? va[31:24] : (lvl == 2) ? 8'(va[23:18]) : 8'(va[17:12]);
          a = {d[31:4], 8'h00} + 36'(idx) * 4;
        end
      end else begin
        case (lvl)
          2'd0: mask = 36'hFFFFFFFF;
          2'd1: mask = 36'hFFFFFF;
          2'd2: mask = 36'h3FFFF;
          default: mask = 36'hFFF;
        endcase
        m_pa = ({d[31:8], 12'h000} & ~mask) | ({4'h0, va} & mask);
        m_wb = !d[5] || (wr && !d[6]);
        nd = d | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (m_wb) begin
          m_k++; m_wb_addr = a; m_wb_data = nd; m_attr = nd[7:0];
        end else begin
          m_attr = d[7:0];
        end
        done = 1;
      end
    end
  endtask

  task automatic cfg_wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic cfg_rd(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1 d = cfg_rdata_o;
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input string tag);
    exp_t e;
    int w0, r0;
    logic [31:0] v;
    model(va, wr);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    w0 = wr_cnt; r0 = rd_cnt;
    e.fault = m_fault; e.pa = m_pa; e.attr = m_attr; e.lat = m_k + 1; e.t0 = cyc; e.tag = tag;
    sb_q.push_back(e);
    req_valid_i = 1; req_vaddr_i = va; req_write_i = wr;
    @(negedge clk_i);
    req_valid_i = 0;
    if (m_en) chk(!req_ready_o, "R12 busy while walking", 64'(req_ready_o), 0);
    while (sb_q.size() != 0) @(negedge clk_i);
    chk(rd_cnt - r0 == m_k - (m_wb ? 1 : 0), {tag, " R4 read count"}, 64'(rd_cnt - r0), 64'(m_k - (m_wb ? 1 : 0)));
    if (m_wb) begin
      chk(wr_cnt - w0 == 1, "R9 one write-back", 64'(wr_cnt - w0), 1);
      chk(rd(m_wb_addr) == m_wb_data, "R9 write-back data", 64'(rd(m_wb_addr)), 64'(m_wb_data));
    end else begin
      chk(wr_cnt == w0, {tag, " R10 no write"}, 64'(wr_cnt - w0), 0);
    end
    if (m_fault) begin
      cfg_rd(11'h300, v);
      chk(v == 32'(m_fsr), {tag, " status"}, 64'(v), 64'(m_fsr));
      cfg_rd(11'h400, v);
      chk(v == va, "R7 fault address", 64'(v), 64'(va));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    // tables: context table at 0x10000, L1 0x20000, L2 0x30000, L3 0x40000
    mem[36'h1000C] = 32'h0000_2001;
    mem[36'h10014] = 32'hABC0_00A7;
    mem[36'h20048] = 32'h0000_3001;
    mem[36'h20154] = 32'h00C0_FFEE;
    mem[36'h20198] = 32'h0000_3001;
    mem[36'h30034] = 32'h0000_4001;
    mem[36'h300A8] = 32'h0DEA_D0A2;
    mem[36'h40014] = 32'h7654_32EE;
    mem[36'h4001C] = 32'h1112_2202;
    mem[36'h40020] = 32'h3334_4426;
    mem[36'h40024] = 32'h0005_0001;

    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(req_ready_o && !resp_valid_o && !mem_req_o, "R1 idle after reset",
        64'({req_ready_o, resp_valid_o, mem_req_o}), 64'(3'b100));
    for (int i = 0; i < 5; i++) begin
      cfg_rd(11'(i * 256), v);
      chk(v == 0, "R1 register reset", 64'(v), 0);
    end

    m_en = 0; m_tptr = 0; m_ctx = 0;
    walk(32'hDEAD_BEEF, 0, "R3 bypass");
    chk(rd_cnt == 0 && wr_cnt == 0, "R3 no memory traffic", 64'(rd_cnt + wr_cnt), 0);

    cfg_wr(11'h100, 32'h0000_100F);
    cfg_rd(11'h100, v);
    chk(v == 32'h1000, "R2 pointer low bits", 64'(v), 64'h1000);
    cfg_wr(11'h200, 32'd3);
    cfg_rd(11'h200, v);
    chk(v == 3, "R2 context", 64'(v), 3);
    cfg_wr(11'h000, 32'h1);
    cfg_rd(11'h000, v);
    chk(v == 1, "R2 control", 64'(v), 1);
    cfg_wr(11'h300, 32'hF);
    cfg_wr(11'h400, 32'h1234);
    cfg_rd(11'h300, v);
    chk(v == 0, "R2 status write ignored", 64'(v), 0);
    cfg_rd(11'h400, v);
    chk(v == 0, "R2 address write ignored", 64'(v), 0);
    cfg_rd(11'h7F0, v);
    chk(v == 0, "R2 unmapped", 64'(v), 0);
    m_en = 1; m_tptr = 32'h1000; m_ctx = 3;

    walk(32'h1234_5678, 0, "R6 level3 read");
    walk(32'h1234_5678, 1, "R10 level3 write marked");
    walk(32'h1234_7ABC, 0, "R9 ref clear");
    walk(32'h1234_7ABC, 0, "R10 after update");
    walk(32'h1234_8123, 0, "R10 read mod clear");
    walk(32'h1234_8123, 1, "R9 write mod clear");
    walk(32'h55AB_CDEF, 0, "R6 level1 leaf");
    walk(32'h66AB_CDEF, 0, "R6 level2 leaf");
    walk(32'h7700_0000, 0, "R7 invalid level1");
    walk(32'h1234_9000, 0, "R8 depth");
    walk(32'h1234_A000, 1, "R7 invalid level3");

    cfg_wr(11'h200, 32'd5); m_ctx = 5;
    walk(32'h89AB_CDEF, 1, "R5 alt leaf level0");
    cfg_wr(11'h200, 32'd6); m_ctx = 6;
    walk(32'h0000_1000, 0, "R7 invalid context");

    cfg_wr(11'h000, 32'h0); m_en = 0;
    walk(32'h1234_5678, 1, "R3 bypass again");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule